// File: doc/BRIEF.md
# I2C Wait and Interrupt Timing Controller

This block decides when an I2C peripheral raises its transfer interrupt and when it stretches the clock by holding SCL low. It serves both the master and the slave role. It covers the address byte and the data bytes in either direction.

The block watches an already synchronised SCL/SDA pair and finds start conditions, stop conditions and SCL edges. It counts the clocks of each byte itself. A separate address comparator supplies the address-match and extension-code indications. The CPU side supplies:

- a wait-point select bit;
- an ACK enable;
- four strobes: wait release, data-register write, start request and stop request.

Any one of the four strobes ends a wait. The block also decides when to pull SDA low for ACK during the ninth clock, and it keeps the ACK choice stable while the bus is held.

Top module: `i2c_wait_ctl`

## Requirements
- R1: After reset, irq_o, scl_hold_o and ack_drive_o are all 0. No event is produced before the first start condition.
- R2: As master, the address byte raises the interrupt and the wait at the falling edge of the 9th clock only, whatever the value of wait9_i. Both outputs are first seen high one clock after the sampled SCL fall.
- R3: As slave, when addr_match_i is 1 during the address byte, the interrupt and the wait come at the 9th falling edge. ack_drive_o is 1 during that 9th clock even with ack_en_i at 0.
- R4: As slave, when the address does not match and no extension code is seen, no interrupt, wait or ACK drive is produced for that address byte or for the data bytes that follow, until the next start.
- R5: As slave, when ext_code_i is 1 during the address byte, the interrupt and the wait come at the falling edge of the 8th clock.
- R6: In data bytes, for a master or a selected slave, wait9_i = 0 places the event at the 8th falling edge and wait9_i = 1 places it at the 9th. There is no event at the other of the two edges.
- R7: While the bus is held, a one-cycle pulse on any of wrel_i, dat_wr_i, start_req_i or stop_req_i drops scl_hold_o on the next clock.
- R8: A stop condition (SDA rising while SCL is high) raises irq_o on the next clock and clears any pending hold.
- R9: When the wait sits at the 8th edge, the ACK driven in the 9th clock of a data byte equals ack_en_i as sampled at the release. Otherwise it equals ack_en_i as sampled at the 8th falling edge.
- R10: A start condition, including a repeated start in the middle of a byte, clears the clock count and makes the next byte an address byte.
- R11: irq_o is a single-cycle pulse. scl_hold_o stays high from the event until a release or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| addr_match_i | input | 1 | Address comparator reports own address |
| ext_code_i | input | 1 | Address comparator reports extension code |
| wait9_i | input | 1 | Data-phase wait point: 0 = 8th edge, 1 = 9th edge |
| ack_en_i | input | 1 | Drive ACK in the 9th clock of data bytes |
| wrel_i | input | 1 | Wait-release strobe |
| dat_wr_i | input | 1 | Data register write strobe |
| start_req_i | input | 1 | Start-condition request strobe |
| stop_req_i | input | 1 | Stop-condition request strobe |
| irq_o | output | 1 | Transfer interrupt pulse |
| scl_hold_o | output | 1 | Hold SCL low (wait) |
| ack_drive_o | output | 1 | Pull SDA low for ACK |

## Verification
The assertions assume that SCL never toggles while scl_hold_o is high, since on a real bus the held line cannot rise. They also assume that the comparator indications stay stable from the address byte through its ACK clock. The stimulus raises SCL only after it has issued a release strobe. It changes SDA only while SCL is low, except to form start and stop conditions. It sets addr_match_i, ext_code_i and master_i before each start and leaves them unchanged until the following stop.

// File: rtl/i2c_wait_pkg.sv
package i2c_wait_pkg;
  typedef struct packed {
    logic scl_fall;
    logic scl_rise;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_bus_edge.sv
module i2c_bus_edge
  import i2c_wait_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.scl_fall = scl_q & ~scl_i;
    ev_o.scl_rise = ~scl_q & scl_i;
    ev_o.start    = scl_q & scl_i & sda_q & ~sda_i;
    ev_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_bit_track.sv
module i2c_bit_track
  import i2c_wait_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bus_ev_t ev_i,
  output logic    addr_phase_o,
  output logic    in_ack_o,
  output logic    fall_data_o,
  output logic    fall_ack_o
);
  localparam int ACK_BIT = BITS + 1;
  localparam int CNT_W   = $clog2(ACK_BIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      active_q     <= 1'b0;
      addr_phase_o <= 1'b0;
      in_ack_o     <= 1'b0;
    end else if (ev_i.start) begin
      cnt_q        <= '0;
      active_q     <= 1'b1;
      addr_phase_o <= 1'b1;
      in_ack_o     <= 1'b0;
    end else if (ev_i.stop) begin
      cnt_q        <= '0;
      active_q     <= 1'b0;
      addr_phase_o <= 1'b0;
      in_ack_o     <= 1'b0;
    end else if (active_q) begin
      if (ev_i.scl_rise && cnt_q != CNT_W'(ACK_BIT)) cnt_q <= cnt_q + 1'b1;
      if (fall_ack_o) begin
        cnt_q        <= '0;
        addr_phase_o <= 1'b0;
        in_ack_o     <= 1'b0;
      end else if (fall_data_o) begin
        in_ack_o <= 1'b1;
      end
    end
  end

  // n-th falling edge follows the n-th rising edge since start
  assign fall_data_o = active_q & ev_i.scl_fall & (cnt_q == CNT_W'(BITS));
  assign fall_ack_o  = active_q & ev_i.scl_fall & (cnt_q == CNT_W'(ACK_BIT));

  p_ack_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ack_o |-> in_ack_o);
endmodule

// File: rtl/i2c_wait_point.sv
module i2c_wait_point (
  input  logic master_i,
  input  logic wait9_i,
  input  logic addr_phase_i,
  input  logic selected_i,
  input  logic addr_match_i,
  input  logic ext_code_i,
  input  logic fall_data_i,
  input  logic fall_ack_i,
  output logic evt_o,
  output logic sel_set_o
);
  always_comb begin
    evt_o     = 1'b0;
    sel_set_o = 1'b0;
    if (addr_phase_i) begin
      if (master_i) begin
        evt_o = fall_ack_i;
      end else if (ext_code_i) begin
        evt_o     = fall_data_i;
        sel_set_o = fall_data_i;
      end else if (addr_match_i) begin
        evt_o     = fall_ack_i;
        sel_set_o = fall_ack_i;
      end
    end else if (master_i || selected_i) begin
      evt_o = wait9_i ? fall_ack_i : fall_data_i;
    end
  end
endmodule

// File: rtl/i2c_wait_ctl.sv
module i2c_wait_ctl
  import i2c_wait_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic master_i,
  input  logic addr_match_i,
  input  logic ext_code_i,
  input  logic wait9_i,
  input  logic ack_en_i,
  input  logic wrel_i,
  input  logic dat_wr_i,
  input  logic start_req_i,
  input  logic stop_req_i,
  output logic irq_o,
  output logic scl_hold_o,
  output logic ack_drive_o
);
  bus_ev_t ev;
  logic addr_phase, in_ack, fall_data, fall_ack;
  logic evt, sel_set, selected_q, ack_lat_q, rel;

  i2c_bus_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
  );

  i2c_bit_track #(.BITS(BITS)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev),
    .addr_phase_o(addr_phase), .in_ack_o(in_ack),
    .fall_data_o(fall_data), .fall_ack_o(fall_ack)
  );

  i2c_wait_point u_point (
    .master_i(master_i), .wait9_i(wait9_i), .addr_phase_i(addr_phase),
    .selected_i(selected_q), .addr_match_i(addr_match_i),
    .ext_code_i(ext_code_i), .fall_data_i(fall_data), .fall_ack_i(fall_ack),
    .evt_o(evt), .sel_set_o(sel_set)
  );

  assign rel = wrel_i | dat_wr_i | start_req_i | stop_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      scl_hold_o <= 1'b0;
      selected_q <= 1'b0;
      ack_lat_q  <= 1'b0;
    end else begin
      irq_o <= evt | ev.stop;
      if (evt)                scl_hold_o <= 1'b1;
      else if (rel | ev.stop) scl_hold_o <= 1'b0;
      if (ev.start || ev.stop) selected_q <= 1'b0;
      else if (sel_set)        selected_q <= 1'b1;
      // ACK level is frozen at the 8th edge, or at release if held there
      if (fall_data && !evt)      ack_lat_q <= ack_en_i;
      else if (scl_hold_o && rel) ack_lat_q <= ack_en_i;
    end
  end

  always_comb begin
    ack_drive_o = 1'b0;
    if (in_ack) begin
      if (addr_phase && !master_i)
        ack_drive_o = ext_code_i ? ack_lat_q : addr_match_i;
      else if (!addr_phase && (master_i || selected_q))
        ack_drive_o = ack_lat_q;
    end
  end

  p_hold_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> irq_o);
  p_unsel_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_phase && !master_i && !selected_q) |-> !evt);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && rel && !evt) |=> !scl_hold_o);
  p_stop_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.stop |=> (irq_o && !scl_hold_o));
  p_irq_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_hold_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !rel && !ev.stop) |=> scl_hold_o);
endmodule

// File: tb/i2c_wait_ctl_bench.sv
module i2c_wait_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, master = 1'b0, amatch = 1'b0, ext = 1'b0;
  logic wait9 = 1'b0, ack_en = 1'b0;
  logic wrel = 1'b0, dwr = 1'b0, sreq = 1'b0, preq = 1'b0;
  logic irq, hold, ackd;

  i2c_wait_ctl u_i2c_wait_ctl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_i(master), .addr_match_i(amatch), .ext_code_i(ext),
    .wait9_i(wait9), .ack_en_i(ack_en), .wrel_i(wrel), .dat_wr_i(dwr),
    .start_req_i(sreq), .stop_req_i(preq),
    .irq_o(irq), .scl_hold_o(hold), .ack_drive_o(ackd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    bit    ck_ih;
    bit    e_irq;
    bit    e_hold;
    bit    ck_ack;
    bit    e_ack;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_tests = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each item in the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.ck_ih) begin
        n_tests++;
        if (irq !== e.e_irq || hold !== e.e_hold) begin
          n_fail++;
          $display("FAIL %s: irq/hold=%b%b expected %b%b at cycle %0d",
                   e.req, irq, hold, e.e_irq, e.e_hold, cyc);
        end
      end
      if (e.ck_ack) begin
        n_tests++;
        if (ackd !== e.e_ack) begin
          n_fail++;
          $display("FAIL %s: ack_drive=%b expected %b at cycle %0d",
                   e.req, ackd, e.e_ack, cyc);
        end
      end
    end
  end

  task automatic push_ih(bit i, bit h, string r);
    exp_t e;
    e = '{cyc + 1, 1'b1, i, h, 1'b0, 1'b0, r};
    q.push_back(e);
  endtask

  task automatic push_ack(bit a, string r);
    exp_t e;
    e = '{cyc + 1, 1'b0, 1'b0, 1'b0, 1'b1, a, r};
    q.push_back(e);
  endtask

  task automatic start_cond(string r);
    sda = 1'b1; @(negedge clk);
    scl = 1'b1; @(negedge clk);
    sda = 1'b0; push_ih(0, 0, r); @(negedge clk);
    scl = 1'b0; push_ih(0, 0, r); @(negedge clk);
  endtask

  task automatic stop_cond(string r);
    sda = 1'b0; @(negedge clk);
    scl = 1'b1; @(negedge clk);
    sda = 1'b1; push_ih(1, 0, r); @(negedge clk);
    push_ih(0, 0, r); @(negedge clk);
  endtask

  task automatic release_wait(int kind, string r);
    case (kind)
      0: wrel = 1'b1;
      1: dwr  = 1'b1;
      2: sreq = 1'b1;
      default: preq = 1'b1;
    endcase
    push_ih(0, 0, r); @(negedge clk);
    wrel = 1'b0; dwr = 1'b0; sreq = 1'b0; preq = 1'b0;
    @(negedge clk);
  endtask

  // one clock with SDA v; ev=1 expects event at this falling edge
  task automatic bit_clk(bit v, bit ev, bit ck_a, bit e_a, string r);
    sda = v; @(negedge clk);
    scl = 1'b1; if (ck_a) push_ack(e_a, r); @(negedge clk);
    @(negedge clk);
    scl = 1'b0; push_ih(ev, ev, r); @(negedge clk);
    push_ih(0, ev, r); @(negedge clk);
  endtask

  // 8 data clocks + ACK clock; ev_at = 0, 8 or 9
  task automatic byte9(bit [7:0] d, int ev_at, int rel_kind, bit ck_a,
                       bit e_a, bit ack_at_rel, string r);
    for (int i = 0; i < 9; i++) begin
      bit v;
      v = (i < 8) ? d[7-i] : 1'b1;
      bit_clk(v, (i + 1) == ev_at, ck_a && i == 8, e_a, r);
      if ((i + 1) == ev_at) begin
        ack_en = ack_at_rel;
        release_wait(rel_kind, r);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, and SCL activity before any start is ignored
    n_tests++;
    if (irq !== 0 || hold !== 0 || ackd !== 0) begin
      n_fail++;
      $display("FAIL R1: outputs=%b%b%b expected 000", irq, hold, ackd);
    end
    master = 1'b1;
    for (int k = 0; k < 10; k++) begin
      scl = 1'b0; push_ih(0, 0, "R1 idle"); @(negedge clk);
      scl = 1'b1; @(negedge clk);
    end
    scl = 1'b0; @(negedge clk);

    // R2: master address at 9th edge with wait9=0; R6 data timing; R7 strobes
    wait9 = 1'b0;
    start_cond("R10 start");
    byte9(8'hA4, 9, 0, 0, 0, 0, "R2 master addr 9th");
    byte9(8'h3C, 8, 1, 0, 0, 0, "R6 master data wait9=0");
    wait9 = 1'b1;
    byte9(8'h5A, 9, 2, 0, 0, 0, "R6 master data wait9=1");
    byte9(8'hC3, 9, 3, 0, 0, 0, "R7 stop request release");
    stop_cond("R8 stop irq");

    // R3: slave match, forced ACK; R9 ACK latched at release
    master = 1'b0; amatch = 1'b1; wait9 = 1'b0; ack_en = 1'b0;
    start_cond("R10 start");
    byte9(8'h6E, 9, 3, 1, 1, 0, "R3 slave match ack forced");
    ack_en = 1'b0;
    byte9(8'h11, 8, 0, 1, 1, 1, "R9 ack set before release");
    ack_en = 1'b1;
    byte9(8'h22, 8, 1, 1, 0, 0, "R9 ack cleared before release");
    ack_en = 1'b1; wait9 = 1'b1;
    byte9(8'h33, 9, 0, 1, 1, 1, "R9 ack sampled at 8th edge");
    // R8: stop while held clears hold
    wait9 = 1'b0;
    for (int i = 0; i < 8; i++) bit_clk(1'b0, i == 7, 0, 0, "R11 hold before stop");
    push_ih(0, 1, "R11 hold sticky"); @(negedge clk);
    push_ih(0, 1, "R11 hold sticky"); @(negedge clk);
    stop_cond("R8 stop clears hold");

    // R4: slave mismatch, no events in address or data
    amatch = 1'b0; ack_en = 1'b1;
    start_cond("R10 start");
    byte9(8'h70, 0, 0, 1, 0, 0, "R4 mismatch addr");
    byte9(8'hFF, 0, 0, 1, 0, 0, "R4 mismatch data");
    stop_cond("R8 stop");

    // R5: extension code at 8th edge
    ext = 1'b1; ack_en = 1'b0;
    start_cond("R10 start");
    byte9(8'hF0, 8, 0, 0, 0, 0, "R5 ext code 8th");
    stop_cond("R8 stop");
    ext = 1'b0;

    // R10: repeated start mid-byte restarts the count
    master = 1'b1;
    start_cond("R10 start");
    for (int i = 0; i < 4; i++) bit_clk(1'b1, 0, 0, 0, "R10 partial byte");
    start_cond("R10 repeated start");
    byte9(8'h96, 9, 0, 0, 0, 0, "R10 addr after restart");
    stop_cond("R8 stop");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule